// File: doc/BRIEF.md
# Automatic Record Level Control with Noise Gate

This block steers a 6-bit programmable-gain code for the record path so that the level of the converted signal settles near a programmable target. It follows the signed samples of one selected channel with a peak detector. On a timed decision it compares the held peak against a target threshold and moves the gain one code (1.5 dB) down when the signal is too loud, or one code up when it is too quiet. The time between decisions comes from a millisecond tick. It depends on separate attack (gain falling) and decay (gain rising) codes, and each code step doubles the sweep time.

A noise gate checks the same peak against a lower threshold. While the signal stays below that threshold, the gate either freezes the gain or, in mute mode, raises a mute flag for the downstream path. An upper gain limit, set in 6 dB steps, caps how far the gain can rise. The analog amplifier and all filtering sit outside this block.

Top module: `alc_ngate`

## Requirements
- R1: After reset the gain code is 23 (0 dB) and the mute flag is 0.
- R2: Channel select 10 follows the left sample input and 01 the right one. With 00 or 11 the block is off: samples and ticks leave the gain unchanged, the peak and interval count are cleared, and mute is 0.
- R3: At a decision where the peak is greater than or equal to the target threshold, the gain falls by one code. The decision is taken after the attack interval of max(1, floor(6·2^a / 41)) ticks.
- R4: At a decision where the peak is below the target threshold, the gain rises by one code. The decision is taken after the decay interval of max(1, floor(24·2^d / 41)) ticks.
- R5: Attack and decay codes above 10 act as code 10.
- R6: The gain never rises above the limit 15 + 4·m, where m is the 3-bit maximum-gain code. It never falls below 0. If the gain is above the limit at a decision that is not gated, it is set to the limit.
- R7: The peak is the largest absolute value among the selected channel's valid samples since the last decision. Every decision clears it.
- R8: With the gate on and the peak below the gate threshold, a decision with gate type 00, 10 or 11 leaves the gain unchanged and mute at 0.
- R9: With gate type 01, a gated decision holds the gain and sets mute to 1. A decision that is not gated clears mute. Mute also returns to 0 one cycle after the gate is switched off, the gate type leaves 01, or the block is switched off. Mute only rises on a tick.
- R10: Thresholds are measured in 1.5 dB units k below full scale, with target k = 19 − t and gate k = 51 − g. The amplitude is floor(2^(23 − floor(k/4)) · F[k mod 4] / 65536), where F = {65536, 55109, 46341, 38968}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe |
| smp_left | input | W | Left sample, two's complement |
| smp_right | input | W | Right sample, two's complement |
| ms_tick | input | 1 | One-cycle millisecond pulse |
| cfg_chan | input | 2 | Channel select |
| cfg_max_gain | input | 3 | Upper gain limit code |
| cfg_target | input | 4 | Target level code |
| cfg_attack | input | 4 | Attack time code |
| cfg_decay | input | 4 | Decay time code |
| cfg_gate_thr | input | 5 | Gate threshold code |
| cfg_gate_type | input | 2 | Gate action |
| cfg_gate_en | input | 1 | Gate enable |
| gain_code | output | 6 | Amplifier gain code |
| mute | output | 1 | Mute request |

## Verification
The properties check on every cycle that the gain moves only after a tick and rises by at most one code, that it stays under the configured limit, and that it is frozen while the block is off. They also check that mute appears only under an enabled mute-type gate and only rises on a tick. The exact attack and decay tick counts, the threshold boundaries one count apart, the use of the absolute value, the peak holding across quiet samples, and the hold and mute behaviour of each gate type can only be shown by the bench scenarios. These include a random sweep of levels, targets and limits.

// File: rtl/alc_pkg.sv
package alc_pkg;
  localparam int unsigned FRAC_BITS = 16;

  typedef enum logic [1:0] {
    CH_OFF   = 2'b00,
    CH_RIGHT = 2'b01,
    CH_LEFT  = 2'b10,
    CH_SPARE = 2'b11
  } chan_e;

  localparam logic [1:0] GATE_MUTE = 2'b01;

  // quarter-octave (1.5 dB) attenuation factors in Q16
  function automatic logic [FRAC_BITS:0] quarter_frac(input logic [1:0] r);
    case (r)
      2'd0:    return 17'd65536;
      2'd1:    return 17'd55109;
      2'd2:    return 17'd46341;
      default: return 17'd38968;
    endcase
  endfunction
endpackage

// File: rtl/alc_thresh.sv
module alc_thresh
  import alc_pkg::*;
#(
  parameter int W = 24
) (
  input  logic [5:0]   level_k,
  output logic [W-1:0] amp
);
  localparam int PW = W + FRAC_BITS + 1;

  logic [W-1:0]  full_scale;
  logic [PW-1:0] prod;

  always_comb begin
    full_scale = {1'b1, {(W-1){1'b0}}} >> level_k[5:2];
    prod       = PW'(full_scale) * PW'(quarter_frac(level_k[1:0]));
    amp        = prod[FRAC_BITS +: W];
  end
endmodule

// File: rtl/alc_peak.sv
module alc_peak
  import alc_pkg::*;
#(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   chan,
  input  logic         smp_valid,
  input  logic [W-1:0] smp_left,
  input  logic [W-1:0] smp_right,
  input  logic         clr,
  output logic [W-1:0] peak
);
  logic [W-1:0] pick, mag, peak_q, peak_d;
  logic         take, peak_en;

  always_comb begin
    pick    = (chan == CH_LEFT) ? smp_left : smp_right;
    mag     = pick[W-1] ? (~pick + 1'b1) : pick;
    take    = smp_valid && ((chan == CH_LEFT) || (chan == CH_RIGHT));
    peak_d  = peak_q;
    if (clr)                      peak_d = take ? mag : '0;
    else if (take && mag > peak_q) peak_d = mag;
    peak_en = (peak_d != peak_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       peak_q <= '0;
    else if (peak_en) peak_q <= peak_d;
  end

  assign peak = peak_q;
endmodule

// File: rtl/alc_step_timer.sv
module alc_step_timer #(
  parameter int ATK_BASE_MS = 6,
  parameter int DCY_BASE_MS = 24,
  parameter int STEPS90     = 41,
  parameter int CODE_MAX    = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic       restart,
  input  logic       dir_down,
  input  logic [3:0] code_atk,
  input  logic [3:0] code_dcy,
  output logic       expire
);
  localparam int BIG     = (ATK_BASE_MS > DCY_BASE_MS) ? ATK_BASE_MS : DCY_BASE_MS;
  localparam int LONGEST = BIG << CODE_MAX;
  localparam int CW      = $clog2(LONGEST + 1);

  function automatic logic [CW-1:0] interval(input int base, input logic [3:0] code);
    logic [3:0]    c;
    logic [CW-1:0] t;
    c = (code > 4'(CODE_MAX)) ? 4'(CODE_MAX) : code;
    t = CW'(base) << c;
    t = t / CW'(STEPS90);
    return (t == '0) ? CW'(1) : t;
  endfunction

  logic [CW-1:0] cnt_q, cnt_d, iv_sel;
  logic [CW:0]   cnt_inc;
  logic          cnt_en;

  always_comb begin
    iv_sel  = dir_down ? interval(ATK_BASE_MS, code_atk) : interval(DCY_BASE_MS, code_dcy);
    cnt_inc = {1'b0, cnt_q} + (CW+1)'(1);
    expire  = ms_tick && !restart && (cnt_inc >= {1'b0, iv_sel});
    if (restart || expire) cnt_d = '0;
    else                   cnt_d = cnt_inc[CW-1:0];
    cnt_en  = restart || ms_tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/alc_gain_ctrl.sv
module alc_gain_ctrl
  import alc_pkg::*;
#(
  parameter logic [5:0] GAIN_RESET = 6'd23
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       expire,
  input  logic       above_target,
  input  logic       below_gate,
  input  logic       gate_en,
  input  logic [1:0] gate_type,
  input  logic [2:0] max_sel,
  output logic [5:0] gain,
  output logic       mute
);
  logic [5:0] gain_q, gain_d, max_code;
  logic       mute_q, mute_d, gated, mute_mode, upd_en;

  always_comb begin
    max_code  = {1'b0, max_sel, 2'b00} + 6'd15;
    gated     = gate_en && below_gate;
    mute_mode = (gate_type == GATE_MUTE);
    gain_d    = gain_q;
    mute_d    = mute_q;
    if (!enable || !gate_en || !mute_mode) mute_d = 1'b0;
    if (enable && expire) begin
      if (gated) begin
        if (mute_mode) mute_d = 1'b1;
      end else begin
        mute_d = 1'b0;
        if (gain_q > max_code)    gain_d = max_code;
        else if (above_target)    gain_d = (gain_q != 6'd0) ? gain_q - 6'd1 : gain_q;
        else if (gain_q < max_code) gain_d = gain_q + 6'd1;
      end
    end
    upd_en = (gain_d != gain_q) || (mute_d != mute_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q <= GAIN_RESET;
      mute_q <= 1'b0;
    end else if (upd_en) begin
      gain_q <= gain_d;
      mute_q <= mute_d;
    end
  end

  assign gain = gain_q;
  assign mute = mute_q;
endmodule

// File: rtl/alc_ngate.sv
module alc_ngate
  import alc_pkg::*;
#(
  parameter int W           = 24,
  parameter int ATK_BASE_MS = 6,
  parameter int DCY_BASE_MS = 24,
  parameter int STEPS90     = 41,
  parameter int CODE_MAX    = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         smp_valid,
  input  logic [W-1:0] smp_left,
  input  logic [W-1:0] smp_right,
  input  logic         ms_tick,
  input  logic [1:0]   cfg_chan,
  input  logic [2:0]   cfg_max_gain,
  input  logic [3:0]   cfg_target,
  input  logic [3:0]   cfg_attack,
  input  logic [3:0]   cfg_decay,
  input  logic [4:0]   cfg_gate_thr,
  input  logic [1:0]   cfg_gate_type,
  input  logic         cfg_gate_en,
  output logic [5:0]   gain_code,
  output logic         mute
);
  localparam logic [5:0] TGT_TOP  = 6'd19;
  localparam logic [5:0] GATE_TOP = 6'd51;

  logic [1:0]   rst_sync_q;
  logic         rst_core_n;
  logic         enable, expire, above_target, below_gate;
  logic [5:0]   k_tgt, k_gate;
  logic [W-1:0] peak, thr_tgt, thr_gate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  always_comb begin
    enable       = (cfg_chan == CH_LEFT) || (cfg_chan == CH_RIGHT);
    k_tgt        = TGT_TOP - {2'b00, cfg_target};
    k_gate       = GATE_TOP - {1'b0, cfg_gate_thr};
    above_target = (peak >= thr_tgt);
    below_gate   = (peak < thr_gate);
  end

  alc_thresh #(.W(W)) u_thr_tgt  (.level_k(k_tgt),  .amp(thr_tgt));
  alc_thresh #(.W(W)) u_thr_gate (.level_k(k_gate), .amp(thr_gate));

  alc_peak #(.W(W)) u_peak (
    .clk(clk), .rst_n(rst_core_n), .chan(cfg_chan), .smp_valid(smp_valid),
    .smp_left(smp_left), .smp_right(smp_right), .clr(expire || !enable), .peak(peak)
  );

  alc_step_timer #(
    .ATK_BASE_MS(ATK_BASE_MS), .DCY_BASE_MS(DCY_BASE_MS),
    .STEPS90(STEPS90), .CODE_MAX(CODE_MAX)
  ) u_timer (
    .clk(clk), .rst_n(rst_core_n), .ms_tick(ms_tick), .restart(!enable),
    .dir_down(above_target), .code_atk(cfg_attack), .code_dcy(cfg_decay),
    .expire(expire)
  );

  alc_gain_ctrl u_gain (
    .clk(clk), .rst_n(rst_core_n), .enable(enable), .expire(expire),
    .above_target(above_target), .below_gate(below_gate),
    .gate_en(cfg_gate_en), .gate_type(cfg_gate_type), .max_sel(cfg_max_gain),
    .gain(gain_code), .mute(mute)
  );
endmodule

// File: rtl/alc_ngate_chk.sv
module alc_ngate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ms_tick,
  input logic [1:0] cfg_chan,
  input logic [2:0] cfg_max_gain,
  input logic [1:0] cfg_gate_type,
  input logic       cfg_gate_en,
  input logic [5:0] gain_code,
  input logic       mute
);
  localparam logic [5:0] GAIN_CEIL = 6'd43;

  assert_gain_ceiling_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gain_code <= GAIN_CEIL);

  assert_step_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ms_tick) |-> $stable(gain_code));

  assert_single_up_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_code > $past(gain_code)) |-> (gain_code == $past(gain_code) + 6'd1));

  assert_up_within_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_code > $past(gain_code)) |->
      (gain_code <= {1'b0, $past(cfg_max_gain), 2'b00} + 6'd15));

  assert_off_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_chan == 2'b00 || cfg_chan == 2'b11) |-> $stable(gain_code));

  assert_mute_needs_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mute |-> ($past(cfg_gate_en) && $past(cfg_gate_type) == 2'b01 &&
              $past(cfg_chan == 2'b01 || cfg_chan == 2'b10)));

  assert_mute_rise_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mute) |-> $past(ms_tick));
endmodule

bind alc_ngate alc_ngate_chk u_chk (.*);

// File: tb/alc_ngate_tb.sv
module alc_ngate_tb;
  localparam int W = 24;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         smp_valid;
  logic [W-1:0] smp_left, smp_right;
  logic         ms_tick;
  logic [1:0]   cfg_chan;
  logic [2:0]   cfg_max_gain;
  logic [3:0]   cfg_target, cfg_attack, cfg_decay;
  logic [4:0]   cfg_gate_thr;
  logic [1:0]   cfg_gate_type;
  logic         cfg_gate_en;
  logic [5:0]   gain_code;
  logic         mute;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  alc_ngate #(.W(W)) u_dut (.*);

  function automatic int unsigned thr(int k);
    int q, r;
    longint unsigned base, f;
    q = k / 4;
    r = k % 4;
    base = 64'd1 << (23 - q);
    f = (r == 0) ? 65536 : (r == 1) ? 55109 : (r == 2) ? 46341 : 38968;
    return int'((base * f) >> 16);
  endfunction

  function automatic int ivl(int base, int code);
    int c, t;
    c = (code > 10) ? 10 : code;
    t = (base << c) / 41;
    return (t == 0) ? 1 : t;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) ms_tick = 1'b1;
    @(negedge clk) ms_tick = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic sample(int l, int r);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_left  = W'(l);
    smp_right = W'(r);
    @(negedge clk) smp_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int gm, mc, t, mx, mag, ch;
    rst_n = 1'b0; smp_valid = 1'b0; smp_left = '0; smp_right = '0; ms_tick = 1'b0;
    cfg_chan = 2'b01; cfg_max_gain = 3'd7; cfg_target = 4'd11; cfg_attack = 4'd0;
    cfg_decay = 4'd0; cfg_gate_thr = 5'd0; cfg_gate_type = 2'b00; cfg_gate_en = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 gain", gain_code, 23);
    check("R1 mute", mute, 0);

    // R10 target boundary (t=11 -> 2^21), R3 down, R4 up, R7 absolute value
    sample(0, 2097152); tick(); check("R10 R3 at threshold", gain_code, 22);
    sample(0, 2097151); tick(); check("R10 R4 below threshold", gain_code, 23);
    sample(0, -2097152); tick(); check("R7 negative peak", gain_code, 22);

    // R2 channel select
    cfg_chan = 2'b10; sample(100, 8000000); tick(); check("R2 left select", gain_code, 23);
    cfg_chan = 2'b01; sample(8000000, 100); tick(); check("R2 right select", gain_code, 24);
    cfg_chan = 2'b00; sample(8000000, 8000000); ticks(3); check("R2 off 00", gain_code, 24);
    cfg_chan = 2'b11; sample(8000000, 8000000); ticks(3); check("R2 off 11", gain_code, 24);
    check("R2 mute off", mute, 0);
    cfg_chan = 2'b01;

    // R7 peak held across a quieter sample, cleared after decision
    sample(0, 8000000); sample(0, 10); tick(); check("R7 held peak", gain_code, 23);
    tick(); check("R7 cleared peak", gain_code, 24);

    // R3 attack interval, R5 code clamp
    cfg_attack = 4'd6; sample(0, 8000000);
    ticks(ivl(6, 6) - 1); check("R3 attack before", gain_code, 24);
    tick(); check("R3 attack step", gain_code, 23);
    cfg_attack = 4'd12; sample(0, 8000000);
    ticks(ivl(6, 12) - 1); check("R5 attack clamp before", gain_code, 23);
    tick(); check("R5 attack clamp step", gain_code, 22);
    cfg_attack = 4'd0;

    // R4 decay interval, R5 code clamp
    cfg_decay = 4'd5;
    ticks(ivl(24, 5) - 1); check("R4 decay before", gain_code, 22);
    tick(); check("R4 decay step", gain_code, 23);
    cfg_decay = 4'd15;
    ticks(ivl(24, 15) - 1); check("R5 decay clamp before", gain_code, 23);
    tick(); check("R5 decay clamp step", gain_code, 24);
    cfg_decay = 4'd0;

    // R6 limits
    cfg_max_gain = 3'd0; tick(); check("R6 clamp to limit", gain_code, 15);
    tick(); check("R6 no rise past limit", gain_code, 15);
    cfg_max_gain = 3'd7; cfg_target = 4'd15;
    for (int i = 0; i < 17; i++) begin sample(0, 8388607); tick(); end
    check("R6 floor", gain_code, 0);
    cfg_target = 4'd11;

    // R8 gate hold (g=0 -> threshold 1217)
    cfg_gate_en = 1'b1; cfg_gate_type = 2'b00;
    sample(0, 1216); tick(); check("R8 hold type00", gain_code, 0);
    check("R8 no mute", mute, 0);
    cfg_gate_type = 2'b10; sample(0, 1216); tick(); check("R8 hold type10", gain_code, 0);
    sample(0, thr(51)); tick(); check("R8 R10 gate boundary passes", gain_code, 1);
    cfg_gate_type = 2'b11; sample(0, 1216); tick(); check("R8 hold type11", gain_code, 1);
    check("R8 type11 no mute", mute, 0);

    // R9 mute gate
    cfg_gate_type = 2'b01; sample(0, 1000); tick();
    check("R9 mute set", mute, 1); check("R9 gain held", gain_code, 1);
    cfg_gate_en = 1'b0; @(negedge clk); check("R9 mute clear on disable", mute, 0);
    cfg_gate_en = 1'b1; sample(0, 1000); tick(); check("R9 mute set again", mute, 1);
    sample(0, 5000); tick(); check("R9 mute clear on loud", mute, 0);
    check("R9 gain rises", gain_code, 2);
    sample(0, 1000); tick(); check("R9 mute set third", mute, 1);
    cfg_gate_type = 2'b00; @(negedge clk); check("R9 mute clear on type", mute, 0);
    cfg_gate_en = 1'b0;

    // Random sweep: R3 R4 R6 R10
    void'($urandom(32'd20240611));
    gm = gain_code;
    for (int i = 0; i < 300; i++) begin
      t  = int'($urandom_range(0, 15));
      mx = int'($urandom_range(0, 7));
      ch = int'($urandom_range(1, 2));
      mag = int'(($urandom & 32'h7FFFFF) >> $urandom_range(0, 23));
      cfg_target = 4'(t); cfg_max_gain = 3'(mx); cfg_chan = 2'(ch);
      if (ch == 2) sample(($urandom & 1) ? -mag : mag, int'($urandom & 32'h7FFFFF));
      else         sample(int'($urandom & 32'h7FFFFF), ($urandom & 1) ? -mag : mag);
      tick();
      mc = 15 + 4 * mx;
      if (gm > mc) gm = mc;
      else if (mag >= int'(thr(19 - t))) gm = (gm > 0) ? gm - 1 : 0;
      else if (gm < mc) gm = gm + 1;
      check("R3 R4 R6 random", gain_code, gm);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule